// File: doc/BRIEF.md
# Monitor-wait address wake unit

This unit lets a core sleep until some other agent writes one memory line. The core first issues a monitor command carrying a virtual address. The unit keeps that address for the translation stage and sets an armed flag. The core then issues a wait command carrying the translated physical address. The unit rounds that address down to the start of its cache line, keeps it, and answers one cycle later whether the core should sleep.

While the unit is both armed and waiting, it snoops coherence invalidation and eviction notices. A notice that falls anywhere inside the watched line wakes the core with a one-cycle pulse. The same notice also leaves a wake-up pending. If a wake-up is still pending when the next wait arrives, that wait returns at once without sleeping and consumes the pending flag.

The state is held in a four-state machine:
- `ST_IDLE`: not armed, not waiting.
- `ST_ARMED`: armed, not waiting.
- `ST_PARKED`: waiting, not armed.
- `ST_WATCH`: armed and waiting.

Transitions:
- A monitor command moves IDLE to ARMED and PARKED to WATCH.
- A wait with no wake-up pending moves IDLE to PARKED and ARMED to WATCH.
- A matching snoop moves WATCH to ARMED.
- No other transition exists.

Top module: `mwait_wake_unit`

## Requirements
- R1: After reset the following outputs are all 0: `wake_o`, `resp_valid_o`, `resp_sleep_o`, `asleep_o` and `mon_vaddr_o`. No wake-up is pending after reset.
- R2: A monitor command (`arm_i`=1) sets the armed flag. It shows its address on `mon_vaddr_o` from the next cycle, and it sets the watched line address to zero. It leaves the waiting flag unchanged.
- R3: A wait (`wait_i`=1) with no wake-up pending stores the line address, which is `wait_paddr_i` with its low log2(LINE_BYTES) bits cleared. It sets waiting (`asleep_o`=1). One cycle later it gives `resp_valid_o`=1 and `resp_sleep_o`=1.
- R4: A wait with a wake-up pending clears the pending flag and leaves waiting and the line unchanged. One cycle later it gives `resp_valid_o`=1 and `resp_sleep_o`=0.
- R5: A snoop (`snoop_i`=1) can act only while the unit is both armed and waiting. A snoop while not armed or not waiting changes nothing.
- R6: A snoop whose address has the same line address as the stored line has three effects. It clears waiting, so `asleep_o` is 0 from the next cycle. It raises `wake_o` for exactly the next cycle. It leaves a wake-up pending.
- R7: A snoop to any other line produces no wake and leaves `asleep_o` set.
- R8: When a wait and a snoop arrive in the same cycle, the wait is applied first. A snoop to the newly latched line therefore wakes the core in the cycle after the wait.
- R9: The armed flag stays set after a wake. A later wait is woken by a snoop without a new monitor command.
- R10: A monitor command given while the unit is waiting keeps it waiting on line address zero. When a monitor command and a wait arrive in the same cycle, the wait's line is the one kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_i | input | 1 | Monitor command strobe |
| arm_vaddr_i | input | ADDR_W | Virtual address to monitor |
| wait_i | input | 1 | Wait command strobe |
| wait_paddr_i | input | ADDR_W | Translated physical address for the wait |
| snoop_i | input | 1 | Invalidation or eviction notice strobe |
| snoop_paddr_i | input | ADDR_W | Physical address of the notice |
| resp_valid_o | output | 1 | Wait response valid, one cycle after the wait |
| resp_sleep_o | output | 1 | 1: core sleeps; 0: return at once |
| wake_o | output | 1 | One-cycle wake pulse |
| asleep_o | output | 1 | Waiting flag |
| mon_vaddr_o | output | ADDR_W | Stored monitor virtual address |

## Verification
A wrong stored line address shows up in two ways. A snoop that should match produces no `wake_o` in the next cycle, or a snoop to a nearby line wakes the core. Either is visible one cycle after the snoop.

A stale or lost pending flag is hidden until the next wait. It then shows as a wrong `resp_sleep_o` one cycle after that wait.

A wrong armed or waiting state appears on `asleep_o` at once, or as a missing or spurious wake on the next matching snoop. The bench places snoops just beside each line boundary and combines commands in the same cycle, so each of these faults reaches a port within a few cycles.

// File: rtl/mww_pkg.sv
package mww_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_ARMED  = 2'b01,
        ST_PARKED = 2'b10,
        ST_WATCH  = 2'b11
    } mww_state_e;
endpackage

// File: rtl/mww_addr_store.sv
module mww_addr_store #(
    parameter int ADDR_W     = 48,
    parameter int LINE_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_i,
    input  logic [ADDR_W-1:0] arm_vaddr_i,
    input  logic              take_i,
    input  logic [ADDR_W-1:0] paddr_i,
    output logic [ADDR_W-1:0] line_next_o,
    output logic [ADDR_W-1:0] vaddr_o
);
    localparam int OFS_W = $clog2(LINE_BYTES);
    localparam logic [ADDR_W-1:0] LINE_MASK = {ADDR_W{1'b1}} << OFS_W;

    logic [ADDR_W-1:0] line_q;

    // Order of updates: monitor first, then wait.
    always_comb begin
        line_next_o = line_q;
        if (arm_i)
            line_next_o = '0;
        if (take_i)
            line_next_o = paddr_i & LINE_MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q  <= '0;
            vaddr_o <= '0;
        end else begin
            line_q <= line_next_o;
            if (arm_i)
                vaddr_o <= arm_vaddr_i;
        end
    end
endmodule

// File: rtl/mww_line_match.sv
module mww_line_match #(
    parameter int ADDR_W     = 48,
    parameter int LINE_BYTES = 64
) (
    input  logic [ADDR_W-1:0] snoop_paddr_i,
    input  logic [ADDR_W-1:0] line_i,
    output logic              hit_o
);
    localparam int OFS_W = $clog2(LINE_BYTES);

    assign hit_o = (snoop_paddr_i[ADDR_W-1:OFS_W] == line_i[ADDR_W-1:OFS_W]);
endmodule

// File: rtl/mwait_wake_unit.sv
module mwait_wake_unit
    import mww_pkg::*;
#(
    parameter int ADDR_W     = 48,
    parameter int LINE_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_i,
    input  logic [ADDR_W-1:0] arm_vaddr_i,
    input  logic              wait_i,
    input  logic [ADDR_W-1:0] wait_paddr_i,
    input  logic              snoop_i,
    input  logic [ADDR_W-1:0] snoop_paddr_i,
    output logic              resp_valid_o,
    output logic              resp_sleep_o,
    output logic              wake_o,
    output logic              asleep_o,
    output logic [ADDR_W-1:0] mon_vaddr_o
);
    mww_state_e state_q, state_d;
    logic              pend_q, pend_d;
    logic              armed_n, waiting_n1, take, hit_line, hit;
    logic [ADDR_W-1:0] line_next;

    // A wait is taken (sleeps) only when no wake-up is pending.
    assign take = wait_i && !pend_q;

    mww_addr_store #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .arm_i       (arm_i),
        .arm_vaddr_i (arm_vaddr_i),
        .take_i      (take),
        .paddr_i     (wait_paddr_i),
        .line_next_o (line_next),
        .vaddr_o     (mon_vaddr_o)
    );

    mww_line_match #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_match (
        .snoop_paddr_i (snoop_paddr_i),
        .line_i        (line_next),
        .hit_o         (hit_line)
    );

    // Flags after the monitor and wait commands of this cycle;
    // the snoop is judged against them (wait before snoop).
    always_comb begin
        armed_n    = (state_q == ST_ARMED) || (state_q == ST_WATCH) || arm_i;
        waiting_n1 = (state_q == ST_PARKED) || (state_q == ST_WATCH) || take;
        hit        = snoop_i && armed_n && waiting_n1 && hit_line;
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case ({armed_n, waiting_n1 && !hit})
            2'b00: state_d = ST_IDLE;
            2'b01: state_d = ST_PARKED;
            2'b10: state_d = ST_ARMED;
            2'b11: state_d = ST_WATCH;
            default: state_d = ST_IDLE;
        endcase
        pend_d = pend_q;
        if (wait_i && pend_q)
            pend_d = 1'b0;
        if (hit)
            pend_d = 1'b1;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
        end
    end

    // Registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid_o <= 1'b0;
            resp_sleep_o <= 1'b0;
            wake_o       <= 1'b0;
        end else begin
            resp_valid_o <= wait_i;
            resp_sleep_o <= take;
            wake_o       <= hit;
        end
    end

    assign asleep_o = (state_q == ST_PARKED) || (state_q == ST_WATCH);
endmodule

// File: rtl/mww_checker.sv
module mww_checker (
    input logic clk,
    input logic rst_n,
    input logic wait_i,
    input logic snoop_i,
    input logic resp_valid_o,
    input logic resp_sleep_o,
    input logic wake_o,
    input logic asleep_o
);
    // R6: a wake pulse leaves the unit not waiting
    a_r6_wake_clears_wait: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> !asleep_o);

    // R7: a wake always follows a snoop in the previous cycle
    a_r7_wake_needs_snoop: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> $past(snoop_i));

    // R3: a response follows a wait by one cycle
    a_r3_resp_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
        wait_i |=> resp_valid_o);

    // R3: a sleep answer leaves the unit waiting unless woken in the same step
    a_r3_sleep_sets_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid_o && resp_sleep_o && !wake_o) |-> asleep_o);

    // R4: the sleep flag is never raised without a response
    a_r4_sleep_in_resp: assert property (@(posedge clk) disable iff (!rst_n)
        resp_sleep_o |-> resp_valid_o);
endmodule

bind mwait_wake_unit mww_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wait_i       (wait_i),
    .snoop_i      (snoop_i),
    .resp_valid_o (resp_valid_o),
    .resp_sleep_o (resp_sleep_o),
    .wake_o       (wake_o),
    .asleep_o     (asleep_o)
);

// File: tb/tb_mwait_wake_unit.sv
module tb_mwait_wake_unit;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 48;
    localparam int LB = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          arm_i = 1'b0, wait_i = 1'b0, snoop_i = 1'b0;
    logic [AW-1:0] arm_vaddr_i = '0, wait_paddr_i = '0, snoop_paddr_i = '0;
    logic          resp_valid_o, resp_sleep_o, wake_o, asleep_o;
    logic [AW-1:0] mon_vaddr_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mwait_wake_unit #(.ADDR_W(AW), .LINE_BYTES(LB)) dut (
        .clk(clk), .rst_n(rst_n),
        .arm_i(arm_i), .arm_vaddr_i(arm_vaddr_i),
        .wait_i(wait_i), .wait_paddr_i(wait_paddr_i),
        .snoop_i(snoop_i), .snoop_paddr_i(snoop_paddr_i),
        .resp_valid_o(resp_valid_o), .resp_sleep_o(resp_sleep_o),
        .wake_o(wake_o), .asleep_o(asleep_o), .mon_vaddr_o(mon_vaddr_o)
    );

    // Behavioural reference model
    bit             m_armed, m_wait, m_pend, m_rv, m_rs, m_wk;
    longint unsigned m_line, m_vaddr;
    longint unsigned mask = ~longint'(LB - 1) & ((longint'(1) << AW) - 1);

    always @(posedge clk) begin
        if (!rst_n) begin
            m_armed = 0; m_wait = 0; m_pend = 0;
            m_rv = 0; m_rs = 0; m_wk = 0;
            m_line = 0; m_vaddr = 0;
        end else begin
            m_rv = 0; m_rs = 0; m_wk = 0;
            if (arm_i) begin
                m_armed = 1; m_vaddr = arm_vaddr_i; m_line = 0;
            end
            if (wait_i) begin
                m_rv = 1;
                if (m_pend) m_pend = 0;
                else begin
                    m_line = wait_paddr_i & mask; m_wait = 1; m_rs = 1;
                end
            end
            if (snoop_i && m_armed && m_wait && ((snoop_paddr_i & mask) == m_line)) begin
                m_wait = 0; m_wk = 1; m_pend = 1;
            end
        end
    end

    task automatic chk(input string req, input longint unsigned act, input longint unsigned exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Compared on every clock, away from the edge
    always @(negedge clk) if (rst_n && !done) begin
        chk("model wake",  wake_o, m_wk);
        chk("model resp",  resp_valid_o, m_rv);
        chk("model sleep", resp_sleep_o, m_rs);
        chk("model asleep", asleep_o, m_wait);
        chk("model vaddr", mon_vaddr_o, m_vaddr);
    end

    task automatic cyc(input bit a, input longint unsigned va, input bit w,
                       input longint unsigned pa, input bit s, input longint unsigned sa);
        arm_i = a; arm_vaddr_i = va[AW-1:0];
        wait_i = w; wait_paddr_i = pa[AW-1:0];
        snoop_i = s; snoop_paddr_i = sa[AW-1:0];
        @(negedge clk);
        arm_i = 0; wait_i = 0; snoop_i = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1
        chk("R1 wake", wake_o, 0); chk("R1 resp", resp_valid_o, 0);
        chk("R1 asleep", asleep_o, 0); chk("R1 vaddr", mon_vaddr_o, 0);
        // R5: snoop while idle
        cyc(0,0,0,0,1,0);          chk("R5 idle snoop", wake_o, 0);
        // R2
        cyc(1,'h1234,0,0,0,0);     chk("R2 vaddr", mon_vaddr_o, 'h1234);
        chk("R2 not waiting", asleep_o, 0);
        // R3
        cyc(0,0,1,'h10047,0,0);    chk("R3 resp", resp_valid_o, 1);
        chk("R3 sleep", resp_sleep_o, 1); chk("R3 asleep", asleep_o, 1);
        // R7: next line and line just below
        cyc(0,0,0,0,1,'h10080);    chk("R7 other line", wake_o, 0);
        cyc(0,0,0,0,1,'h1003F);    chk("R7 below line", wake_o, 0);
        chk("R7 still asleep", asleep_o, 1);
        // R6: last byte of the line
        cyc(0,0,0,0,1,'h1007F);    chk("R6 wake", wake_o, 1);
        chk("R6 awake", asleep_o, 0);
        @(negedge clk);            chk("R6 pulse one cycle", wake_o, 0);
        // R4: pending consumed
        cyc(0,0,1,'h2000,0,0);     chk("R4 resp", resp_valid_o, 1);
        chk("R4 no sleep", resp_sleep_o, 0); chk("R4 asleep", asleep_o, 0);
        // R9: same monitor reused
        cyc(0,0,1,'h2000,0,0);     chk("R9 sleep", resp_sleep_o, 1);
        cyc(0,0,0,0,1,'h2010);     chk("R9 wake without rearm", wake_o, 1);
        cyc(0,0,1,'h9000,0,0);     chk("R4 consume", resp_sleep_o, 0);
        // R8: wait and snoop together
        cyc(0,0,1,'h3000,1,'h3008); chk("R8 sleep", resp_sleep_o, 1);
        chk("R8 wake", wake_o, 1);
        cyc(0,0,1,'h9000,0,0);     chk("R4 consume 2", resp_sleep_o, 0);
        // R10: arm while waiting -> line zero
        cyc(0,0,1,'h4000,0,0);     chk("R10 sleep", asleep_o, 1);
        cyc(1,'h55,0,0,0,0);       chk("R10 still asleep", asleep_o, 1);
        cyc(0,0,0,0,1,'h4000);     chk("R10 old line ignored", wake_o, 0);
        cyc(0,0,0,0,1,'h0020);     chk("R10 line zero wakes", wake_o, 1);
        cyc(0,0,1,'h9000,0,0);     chk("R4 consume 3", resp_sleep_o, 0);
        // R10: arm and wait same cycle keeps wait line
        cyc(1,'h66,1,'h7040,0,0);  chk("R10 same-cycle sleep", resp_sleep_o, 1);
        cyc(0,0,0,0,1,'h0);        chk("R10 zero ignored", wake_o, 0);
        cyc(0,0,0,0,1,'h7044);     chk("R10 wait line wins", wake_o, 1);
        // R5: waiting but not armed
        rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
        cyc(0,0,1,'h5000,0,0);     chk("R5 parked", asleep_o, 1);
        cyc(0,0,0,0,1,'h5000);     chk("R5 unarmed snoop", wake_o, 0);
        chk("R5 still asleep", asleep_o, 1);
        repeat (2) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule